// File: doc/BRIEF.md
# Marker-Matched Sample Capture Controller

This block watches a stream of 16-bit playback samples. A rising edge on the left or right word clock marks each new sample. A channel-select input chooses which of the two word clocks counts. Before a search begins, a host loads a reference sequence of 42 samples into the marker store. The block then starts the player and compares the live stream with that sequence. When the newest 42 samples equal the reference, the block writes the samples that follow into an external capture buffer through a one-cycle write port, one address after another, until the buffer is full.

When the capture buffer is full, the block rewinds the transport and raises a done flag. If no match turns up within a programmable number of samples, the block rewinds and raises a fail flag instead. An interactive mode skips the marker. In that mode the block writes every sample into the buffer as a ring until an external stop input is asserted. Calling the block with the last 42 samples of one record as the marker for the next record gives back-to-back records.

Top module: `marker_capture_ctrl`

## Requirements
- R1: The marker store holds 42 entries, entry 0 being the oldest sample of the sequence. A write with `mk_we` high stores `mk_wdata` at `mk_addr` only while the block is idle. Writes while busy, and writes to an address of 42 or above, change nothing.
- R2: A qualifying sample is a rising edge of the word clock picked by `chan_sel` (0 = left, 1 = right). `sample_in` is taken on that same clock edge. Edges on the other word clock are ignored. Qualifying edges arrive at least 4 clock cycles apart.
- R3: Matching has two stages. The newest 4 samples are first compared with the last 4 marker entries. Only a hit there lets the full comparison decide. A match needs the last 42 qualifying samples of the current search to equal the marker in order. Capture begins on the third clock edge after the qualifying edge that completes the match.
- R4: During capture, each qualifying sample gives a one-cycle `cap_we` pulse in the cycle after its edge, with `cap_wdata` equal to the sample. Addresses run 0, 1, 2 and so on. After CAP_DEPTH writes, capture ends and no further writes occur.
- R5: A timeout counter is loaded from `timeout_len` at start. It drops by one for each qualifying sample during the search and does not go below 0, so a load of 0 acts like 1. When the check for a sample finds no match and the count is 0, the search ends with a rewind and a fail. A match on the sample that brought the count to 0 still succeeds.
- R6: `transport` shows 2'b11 (stop) while idle and 2'b00 (play) while searching, capturing or ring filling. After each run it shows 2'b10 (rewind) for REWIND_CYC cycles and then returns to idle.
- R7: `done` rises when the rewind ends after a full capture or an interactive stop. `fail` rises when the rewind ends after a timeout. Both stay unchanged until the next accepted start clears them, and they are never high together.
- R8: `busy` is high from an accepted start until the rewind ends. A `start` pulse while busy is ignored, together with its mode and timeout inputs.
- R9: With `interactive` high at start, no marker is used. Each qualifying sample is written at the next address, wrapping from CAP_DEPTH-1 to 0, until `user_stop` is high at a clock edge. That edge writes nothing and begins the rewind.
- R10: After reset the block is idle, `transport` is 2'b11, and `busy`, `done`, `fail` and `cap_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_sel | input | 1 | Word clock choice: 0 left, 1 right |
| wclk_left | input | 1 | Left channel word clock |
| wclk_right | input | 1 | Right channel word clock |
| sample_in | input | SW | Sample data, valid at the word clock rising edge |
| start | input | 1 | Start request (accepted only when idle) |
| interactive | input | 1 | Mode chosen at start: 1 ring fill, 0 marker search |
| user_stop | input | 1 | Ends an interactive ring fill |
| timeout_len | input | TMO_W | Search limit in qualifying samples |
| mk_we | input | 1 | Marker store write enable |
| mk_addr | input | clog2(MARKER_LEN) | Marker store address |
| mk_wdata | input | SW | Marker store write data |
| cap_we | output | 1 | Capture buffer write strobe |
| cap_addr | output | clog2(CAP_DEPTH) | Capture buffer address |
| cap_wdata | output | SW | Capture buffer write data |
| transport | output | 2 | Transport code: 00 play, 11 stop, 10 rewind |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run succeeded |
| fail | output | 1 | Last run timed out |

## Verification
The bench builds the block with a 16-entry capture buffer, a 6-cycle rewind and a 16-bit timeout, and keeps the 42-entry marker with a 4-sample prefix. The small buffer puts the buffer-full stop and the ring wrap within a few dozen samples. Timeout loads of 0, 10, 42 and 50 cover a search that ends on its first sample, a plain timeout, a match on the very last allowed sample, and a sequence that passes the prefix check but fails the full one.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_CAPTURE,
        ST_RING,
        ST_REWIND
    } mcc_state_e;

    typedef enum logic [1:0] {
        XPT_PLAY   = 2'b00,
        XPT_REWIND = 2'b10,
        XPT_STOP   = 2'b11
    } xpt_code_e;

    typedef struct packed {
        logic done;
        logic fail;
    } run_result_t;

    localparam int NUM_CHAN = 2;

    function automatic xpt_code_e xpt_of(mcc_state_e s);
        case (s)
            ST_IDLE:   return XPT_STOP;
            ST_REWIND: return XPT_REWIND;
            default:   return XPT_PLAY;
        endcase
    endfunction

endpackage

// File: rtl/mcc_strobe_sel.sv
module mcc_strobe_sel
    import mcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chan_sel,
    input  logic wclk_left,
    input  logic wclk_right,
    output logic strb
);
    logic [NUM_CHAN-1:0] wclk_v;
    logic [NUM_CHAN-1:0] prev_q;
    logic [NUM_CHAN-1:0] rise;

    assign wclk_v = {wclk_right, wclk_left};

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= wclk_v;
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_edge
        assign rise[c] = wclk_v[c] & ~prev_q[c];
    end

    assign strb = rise[chan_sel];

endmodule

// File: rtl/mcc_marker_match.sv
module mcc_marker_match #(
    parameter int SW         = 16,
    parameter int MARKER_LEN = 42,
    parameter int PREFIX_LEN = 4,
    localparam int MAW = $clog2(MARKER_LEN),
    localparam int HCW = $clog2(MARKER_LEN + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mk_we,
    input  logic [MAW-1:0] mk_addr,
    input  logic [SW-1:0]  mk_wdata,
    input  logic           shift_en,
    input  logic           clr,
    input  logic [SW-1:0]  sample,
    output logic           eval_q,
    output logic           match_q
);
    logic [SW-1:0]         marker [MARKER_LEN];
    logic [SW-1:0]         hist   [MARKER_LEN];
    logic [HCW-1:0]        hist_cnt;
    logic [MARKER_LEN-1:0] eq_vec;
    logic                  prefix_eq;
    logic                  rest_eq;
    logic                  new_q;
    logic                  chk_q;
    logic                  quick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MARKER_LEN; i++) marker[i] <= '0;
        end else if (mk_we && (int'(mk_addr) < MARKER_LEN)) begin
            marker[mk_addr] <= mk_wdata;
        end
    end

    // hist[0] holds the newest sample
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < MARKER_LEN; i++) hist[i] <= '0;
            hist_cnt <= '0;
        end else if (shift_en) begin
            hist[0] <= sample;
            for (int i = 1; i < MARKER_LEN; i++) hist[i] <= hist[i-1];
            if (hist_cnt != HCW'(MARKER_LEN)) hist_cnt <= hist_cnt + 1'b1;
        end
    end

    for (genvar i = 0; i < MARKER_LEN; i++) begin : g_cmp
        assign eq_vec[i] = (marker[i] == hist[MARKER_LEN-1-i]);
    end

    assign prefix_eq = &eq_vec[MARKER_LEN-1 -: PREFIX_LEN];
    assign rest_eq   = &eq_vec[MARKER_LEN-PREFIX_LEN-1:0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            new_q   <= 1'b0;
            chk_q   <= 1'b0;
            quick_q <= 1'b0;
            eval_q  <= 1'b0;
            match_q <= 1'b0;
        end else begin
            new_q   <= shift_en;
            chk_q   <= new_q;
            quick_q <= new_q && (hist_cnt >= HCW'(PREFIX_LEN)) && prefix_eq;
            eval_q  <= chk_q;
            match_q <= chk_q && quick_q && (hist_cnt == HCW'(MARKER_LEN)) && rest_eq;
        end
    end

    // R3
    match_after_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        match_q |-> $past(quick_q));

    // R3
    match_only_on_eval_chk: assert property (@(posedge clk) disable iff (rst)
        match_q |-> eval_q);

endmodule

// File: rtl/mcc_seq_ctrl.sv
module mcc_seq_ctrl
    import mcc_pkg::*;
#(
    parameter int SW         = 16,
    parameter int CAP_DEPTH  = 65536,
    parameter int TMO_W      = 24,
    parameter int REWIND_CYC = 8,
    localparam int CAW = (CAP_DEPTH > 1) ? $clog2(CAP_DEPTH) : 1,
    localparam int RCW = (REWIND_CYC > 1) ? $clog2(REWIND_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             interactive,
    input  logic             user_stop,
    input  logic [TMO_W-1:0] timeout_len,
    input  logic             strb,
    input  logic [SW-1:0]    sample,
    input  logic             eval_q,
    input  logic             match_q,
    output mcc_state_e       state,
    output logic             idle,
    output logic             clr,
    output logic             cap_we,
    output logic [CAW-1:0]   cap_addr,
    output logic [SW-1:0]    cap_wdata,
    output run_result_t      result
);
    localparam logic [CAW-1:0] LAST_ADDR = CAW'(CAP_DEPTH - 1);
    localparam logic [RCW-1:0] REW_LOAD  = RCW'(REWIND_CYC - 1);

    logic [TMO_W-1:0] tmo_cnt;
    logic [CAW-1:0]   wr_ptr;
    logic [RCW-1:0]   rew_cnt;
    run_result_t      pend;

    assign idle = (state == ST_IDLE);
    assign clr  = idle && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tmo_cnt   <= '0;
            wr_ptr    <= '0;
            rew_cnt   <= '0;
            pend      <= '0;
            result    <= '0;
            cap_we    <= 1'b0;
            cap_addr  <= '0;
            cap_wdata <= '0;
        end else begin
            cap_we <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= interactive ? ST_RING : ST_SEARCH;
                        tmo_cnt <= timeout_len;
                        wr_ptr  <= '0;
                        pend    <= '0;
                        result  <= '0;
                    end
                end
                ST_SEARCH: begin
                    if (strb) tmo_cnt <= (tmo_cnt == '0) ? '0 : tmo_cnt - 1'b1;
                    if (eval_q) begin
                        if (match_q) begin
                            state <= ST_CAPTURE;
                        end else if (tmo_cnt == '0) begin
                            state   <= ST_REWIND;
                            rew_cnt <= REW_LOAD;
                            pend    <= '{done: 1'b0, fail: 1'b1};
                        end
                    end
                end
                ST_CAPTURE: begin
                    if (strb) begin
                        cap_we    <= 1'b1;
                        cap_addr  <= wr_ptr;
                        cap_wdata <= sample;
                        if (wr_ptr == LAST_ADDR) begin
                            state   <= ST_REWIND;
                            rew_cnt <= REW_LOAD;
                            pend    <= '{done: 1'b1, fail: 1'b0};
                        end else begin
                            wr_ptr <= wr_ptr + 1'b1;
                        end
                    end
                end
                ST_RING: begin
                    if (user_stop) begin
                        state   <= ST_REWIND;
                        rew_cnt <= REW_LOAD;
                        pend    <= '{done: 1'b1, fail: 1'b0};
                    end else if (strb) begin
                        cap_we    <= 1'b1;
                        cap_addr  <= wr_ptr;
                        cap_wdata <= sample;
                        wr_ptr    <= (wr_ptr == LAST_ADDR) ? '0 : wr_ptr + 1'b1;
                    end
                end
                ST_REWIND: begin
                    if (rew_cnt == '0) begin
                        state  <= ST_IDLE;
                        result <= pend;
                    end else begin
                        rew_cnt <= rew_cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(result.done && result.fail));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state inside {ST_SEARCH, ST_CAPTURE, ST_RING}) |=> $stable(result));

    // R5
    fail_after_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(result.fail) |-> (tmo_cnt == '0));

    // R4
    write_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        cap_we |-> $past(strb));

endmodule

// File: rtl/marker_capture_ctrl.sv
module marker_capture_ctrl
    import mcc_pkg::*;
#(
    parameter int SW         = 16,
    parameter int MARKER_LEN = 42,
    parameter int PREFIX_LEN = 4,
    parameter int CAP_DEPTH  = 65536,
    parameter int TMO_W      = 24,
    parameter int REWIND_CYC = 8,
    localparam int MAW = $clog2(MARKER_LEN),
    localparam int CAW = (CAP_DEPTH > 1) ? $clog2(CAP_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_sel,
    input  logic             wclk_left,
    input  logic             wclk_right,
    input  logic [SW-1:0]    sample_in,
    input  logic             start,
    input  logic             interactive,
    input  logic             user_stop,
    input  logic [TMO_W-1:0] timeout_len,
    input  logic             mk_we,
    input  logic [MAW-1:0]   mk_addr,
    input  logic [SW-1:0]    mk_wdata,
    output logic             cap_we,
    output logic [CAW-1:0]   cap_addr,
    output logic [SW-1:0]    cap_wdata,
    output logic [1:0]       transport,
    output logic             busy,
    output logic             done,
    output logic             fail
);
    logic        strb;
    logic        eval_q;
    logic        match_q;
    logic        idle;
    logic        clr;
    mcc_state_e  state;
    run_result_t result;

    mcc_strobe_sel u_strobe (
        .clk        (clk),
        .rst        (rst),
        .chan_sel   (chan_sel),
        .wclk_left  (wclk_left),
        .wclk_right (wclk_right),
        .strb       (strb)
    );

    mcc_marker_match #(
        .SW         (SW),
        .MARKER_LEN (MARKER_LEN),
        .PREFIX_LEN (PREFIX_LEN)
    ) u_match (
        .clk      (clk),
        .rst      (rst),
        .mk_we    (mk_we && idle),
        .mk_addr  (mk_addr),
        .mk_wdata (mk_wdata),
        .shift_en (strb && (state == ST_SEARCH)),
        .clr      (clr),
        .sample   (sample_in),
        .eval_q   (eval_q),
        .match_q  (match_q)
    );

    mcc_seq_ctrl #(
        .SW         (SW),
        .CAP_DEPTH  (CAP_DEPTH),
        .TMO_W      (TMO_W),
        .REWIND_CYC (REWIND_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .interactive (interactive),
        .user_stop   (user_stop),
        .timeout_len (timeout_len),
        .strb        (strb),
        .sample      (sample_in),
        .eval_q      (eval_q),
        .match_q     (match_q),
        .state       (state),
        .idle        (idle),
        .clr         (clr),
        .cap_we      (cap_we),
        .cap_addr    (cap_addr),
        .cap_wdata   (cap_wdata),
        .result      (result)
    );

    assign transport = xpt_of(state);
    assign busy      = !idle;
    assign done      = result.done;
    assign fail      = result.fail;

    // R6
    rewind_before_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(transport) == XPT_REWIND));

endmodule

// File: tb/marker_capture_ctrl_tb_top.sv
module marker_capture_ctrl_tb_top;
    localparam int SW  = 16;
    localparam int ML  = 42;
    localparam int CD  = 16;
    localparam int TW  = 16;
    localparam int RC  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chan_sel = 1'b0;
    logic          wclk_left = 1'b0;
    logic          wclk_right = 1'b0;
    logic [SW-1:0] sample_in = '0;
    logic          start = 1'b0;
    logic          interactive = 1'b0;
    logic          user_stop = 1'b0;
    logic [TW-1:0] timeout_len = '0;
    logic          mk_we = 1'b0;
    logic [5:0]    mk_addr = '0;
    logic [SW-1:0] mk_wdata = '0;
    logic          cap_we;
    logic [3:0]    cap_addr;
    logic [SW-1:0] cap_wdata;
    logic [1:0]    transport;
    logic          busy;
    logic          done;
    logic          fail;

    int n_chk  = 0;
    int n_fail = 0;
    int n_caps = 0;
    logic [SW-1:0] last_cap_data;
    int            last_cap_addr;

    always #5 clk = ~clk;

    marker_capture_ctrl #(
        .SW(SW), .MARKER_LEN(ML), .PREFIX_LEN(4),
        .CAP_DEPTH(CD), .TMO_W(TW), .REWIND_CYC(RC)
    ) dut_i (
        .clk(clk), .rst(rst), .chan_sel(chan_sel),
        .wclk_left(wclk_left), .wclk_right(wclk_right),
        .sample_in(sample_in), .start(start), .interactive(interactive),
        .user_stop(user_stop), .timeout_len(timeout_len),
        .mk_we(mk_we), .mk_addr(mk_addr), .mk_wdata(mk_wdata),
        .cap_we(cap_we), .cap_addr(cap_addr), .cap_wdata(cap_wdata),
        .transport(transport), .busy(busy), .done(done), .fail(fail)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // states: 0 idle, 1 search, 2 capture, 3 ring, 4 rewind
    int            ms = 0;
    logic [SW-1:0] m_mark [ML];
    logic [SW-1:0] m_hist [$];
    int            m_tmo, m_wp, m_ev, m_rew;
    bit            m_match, m_pd, m_pf, m_done, m_fail;
    bit            m_pl, m_pr, m_rise;
    bit            e_we;
    int            e_addr;
    logic [SW-1:0] e_data;
    bit            seen_edge = 0;

    always @(posedge clk) begin
        seen_edge = 1;
        if (rst) begin
            ms = 0; m_tmo = 0; m_wp = 0; m_ev = 0; m_rew = 0;
            m_done = 0; m_fail = 0; m_pd = 0; m_pf = 0; m_match = 0;
            m_pl = 0; m_pr = 0; e_we = 0; e_addr = 0; e_data = '0;
            m_hist.delete();
            for (int i = 0; i < ML; i++) m_mark[i] = '0;
        end else begin
            m_rise = chan_sel ? (wclk_right && !m_pr) : (wclk_left && !m_pl);
            m_pl = wclk_left;
            m_pr = wclk_right;
            e_we = 0;
            case (ms)
                0: begin
                    if (mk_we && mk_addr < ML) m_mark[mk_addr] = mk_wdata;
                    if (start) begin
                        ms = interactive ? 3 : 1;
                        m_tmo = int'(timeout_len);
                        m_wp = 0; m_done = 0; m_fail = 0; m_ev = 0;
                        m_hist.delete();
                    end
                end
                1: begin
                    if (m_ev > 0) begin
                        m_ev--;
                        if (m_ev == 0) begin
                            if (m_match) ms = 2;
                            else if (m_tmo == 0) begin
                                ms = 4; m_rew = RC; m_pd = 0; m_pf = 1;
                            end
                        end
                    end
                    if (m_rise) begin
                        m_hist.push_back(sample_in);
                        if (m_hist.size() > ML) void'(m_hist.pop_front());
                        if (m_tmo > 0) m_tmo--;
                        m_match = (m_hist.size() == ML);
                        for (int i = 0; i < m_hist.size(); i++)
                            if (m_hist[i] != m_mark[i]) m_match = 0;
                        m_ev = 3;
                    end
                end
                2: begin
                    if (m_rise) begin
                        e_we = 1; e_addr = m_wp; e_data = sample_in;
                        if (m_wp == CD - 1) begin
                            ms = 4; m_rew = RC; m_pd = 1; m_pf = 0;
                        end else m_wp++;
                    end
                end
                3: begin
                    if (user_stop) begin
                        ms = 4; m_rew = RC; m_pd = 1; m_pf = 0;
                    end else if (m_rise) begin
                        e_we = 1; e_addr = m_wp; e_data = sample_in;
                        m_wp = (m_wp + 1) % CD;
                    end
                end
                default: begin
                    m_rew--;
                    if (m_rew == 0) begin
                        ms = 0; m_done = m_pd; m_fail = m_pf;
                    end
                end
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (seen_edge) begin
            chk(transport == ((ms == 0) ? 2'b11 : (ms == 4) ? 2'b10 : 2'b00),
                "R6", "transport", transport, ms);
            chk(busy == (ms != 0), "R8", "busy", busy, ms != 0);
            chk(done == m_done, "R7", "done", done, m_done);
            chk(fail == m_fail, "R7", "fail", fail, m_fail);
            chk(cap_we == e_we, (ms == 3) ? "R9" : "R4", "cap_we", cap_we, e_we);
            if (e_we && cap_we) begin
                chk(int'(cap_addr) == e_addr, (ms == 3) ? "R9" : "R4", "cap_addr", cap_addr, e_addr);
                chk(cap_wdata == e_data, (ms == 3) ? "R9" : "R4", "cap_wdata", cap_wdata, e_data);
            end
            if (cap_we) begin
                n_caps++;
                last_cap_data = cap_wdata;
                last_cap_addr = int'(cap_addr);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [SW-1:0] mval(input int i);
        return {4'hA, 12'(i * 37 + 5)};
    endfunction

    function automatic logic [SW-1:0] nval(input int i);
        return {4'h5, 12'(i * 11 + 3)};
    endfunction

    task automatic send(input bit ch, input logic [SW-1:0] v);
        @(posedge clk); #2;
        sample_in = v;
        if (ch) wclk_right = 1'b1; else wclk_left = 1'b1;
        @(posedge clk);
        @(posedge clk); #2;
        wclk_left = 1'b0;
        wclk_right = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic mk_write(input int a, input logic [SW-1:0] d);
        @(posedge clk); #2;
        mk_we = 1'b1; mk_addr = 6'(a); mk_wdata = d;
        @(posedge clk); #2;
        mk_we = 1'b0;
    endtask

    task automatic do_start(input bit inter, input int tmo);
        @(posedge clk); #2;
        start = 1'b1; interactive = inter; timeout_len = TW'(tmo);
        @(posedge clk); #2;
        start = 1'b0; interactive = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        @(negedge clk);
        while (busy && k < 5000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(transport == 2'b11, "R10", "reset transport", transport, 3);
        chk(!busy && !done && !fail && !cap_we, "R10", "reset flags",
            {busy, done, fail, cap_we}, 0);

        // R1: load marker, plus an out-of-range write
        for (int i = 0; i < ML; i++) mk_write(i, mval(i));
        mk_write(45, 16'hDEAD);

        // search with noise, marker, then data; R1 write and R8 start while busy
        n_caps = 0;
        do_start(0, 200);
        mk_write(0, 16'hBEEF);
        do_start(1, 3);
        for (int i = 0; i < 7; i++) send(0, nval(i));
        for (int i = 0; i < ML; i++) send(0, mval(i));
        for (int i = 0; i < CD + 2; i++) send(0, 16'h1000 + SW'(i));
        wait_idle();
        chk(done && !fail, "R3", "marker match success", {done, fail}, 2'b10);
        chk(n_caps == CD, "R4", "write count at full buffer", n_caps, CD);
        chk(last_cap_data == 16'h1000 + SW'(CD - 1), "R4", "last captured", last_cap_data, 16'h1000 + CD - 1);
        chk(done, "R1", "marker unchanged by busy write", done, 1);

        // R5: plain timeout
        do_start(0, 10);
        for (int i = 0; i < 12; i++) send(0, nval(i));
        wait_idle();
        chk(fail && !done, "R5", "timeout fail", {done, fail}, 2'b01);

        // R5: match on the very last allowed sample wins
        n_caps = 0;
        do_start(0, ML);
        for (int i = 0; i < ML; i++) send(0, mval(i));
        for (int i = 0; i < CD; i++) send(0, 16'h2000 + SW'(i));
        wait_idle();
        chk(done && !fail, "R5", "match on final sample", {done, fail}, 2'b10);

        // R3: prefix matches but an earlier entry differs
        do_start(0, 50);
        for (int i = 0; i < ML; i++) send(0, (i == 5) ? 16'h0BAD : mval(i));
        for (int i = 0; i < 8; i++) send(0, nval(i));
        wait_idle();
        chk(fail && !done, "R3", "near-miss rejected", {done, fail}, 2'b01);

        // R2: right channel selected, left-channel marker ignored
        @(posedge clk); #2 chan_sel = 1'b1;
        n_caps = 0;
        do_start(0, 150);
        for (int i = 0; i < ML; i++) send(0, mval(i));
        chk(busy && n_caps == 0, "R2", "other channel ignored", n_caps, 0);
        for (int i = 0; i < ML; i++) send(1, mval(i));
        for (int i = 0; i < CD; i++) send(1, 16'h3000 + SW'(i));
        wait_idle();
        chk(done && n_caps == CD, "R2", "right channel capture", n_caps, CD);
        @(posedge clk); #2 chan_sel = 1'b0;

        // R5: load of zero behaves like one
        do_start(0, 0);
        send(0, nval(1));
        wait_idle();
        chk(fail && !done, "R5", "zero timeout", {done, fail}, 2'b01);

        // R9: interactive ring fill with wrap
        n_caps = 0;
        do_start(1, 0);
        for (int i = 0; i < 20; i++) send(0, 16'h4000 + SW'(i));
        @(posedge clk); #2 user_stop = 1'b1;
        @(posedge clk); #2 user_stop = 1'b0;
        wait_idle();
        chk(done && !fail, "R9", "ring stop done", {done, fail}, 2'b10);
        chk(n_caps == 20 && last_cap_addr == 3, "R9", "ring wrap address", last_cap_addr, 3);

        repeat (5) @(posedge clk);
        finish_run();
    end

endmodule